// File: doc/BRIEF.md
# Memory Access Port Register Engine

This block sits behind the access-port request channel of a debug port and turns register accesses into memory bus transactions. It keeps a control word that selects the access size and the address-stepping mode, and an address register that points into target memory. It also has one streaming data register and four banked data windows. Every access to a data register becomes exactly one 32-bit bus transaction, with byte enables and byte-lane placement derived from the current size and address.

Requests arrive on a valid/ready channel. A request is accepted in a cycle where both `req_valid` and `req_ready` are high. Every accepted request produces exactly one response on a valid/ready response channel. The response is held, with stable data, until `rsp_ready` is seen high. `req_ready` stays low while a response is waiting or a data read is in progress. When overrun detection is off (`orun_en` low), `req_ready` also stays low while a bus access is outstanding, so the requester is back-pressured. When overrun detection is on, `req_ready` stays high and a request that arrives during an outstanding access is rejected. Writes to data registers are posted: the response returns at once and the bus transaction completes in the background. Reads of data registers respond only when the bus returns data. An access counts as outstanding from the cycle after acceptance through the cycle of its bus response.

The bus side is a request/response master. `mem_req_valid` with its fields is held until `mem_req_ready`. The block accepts `mem_rsp_valid` in any cycle, and only one access is ever outstanding.

Top module: `memap_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `mem_req_valid`, `sticky_orun` and `sticky_err` are 0, and both the control word and the address register read as zero.
- R2: Register offsets (taken from `req_addr[4:2]` with `req_addr[7:5]` zero) are 0x00 for the control word, 0x04 for the address register, 0x0C for the data register and 0x10/0x14/0x18/0x1C for banks 0..3. The control word holds size in bits [1:0] (0=byte, 1=halfword, 2 or 3=word), stepping mode in bits [5:4] (0=none, 1=single, 2=packed, 3=none) and a read-only busy flag in bit 7. Every other offset reads as zero, and writes to such offsets leave all state unchanged.
- R3: A data-register write in single or none mode drives the bus address equal to the address register. A word uses enables 4'hF with unchanged data. A byte uses enable 1<<A[1:0] with data[7:0] shifted left by 8*A[1:0]. A halfword uses enables 4'h3 or 4'hC, chosen by A[1], with data[15:0] shifted left by 16*A[1].
- R4: A data-register read in single or none mode returns the selected lane shifted down to bit 0 and zero-extended: 8 bits for byte, 16 bits for halfword (lane from A[1]), or the whole word.
- R5: In single mode the address register advances by 1, 2 or 4 after each successful data-register transfer. In mode none it does not change.
- R6: Stepping changes only address bits [9:0] and wraps within them, so an aligned 1 KB window is never left.
- R7: In packed mode a byte access enables lanes A[1:0] through 3 (enables 4'hF<<A[1:0]) and advances by 4-A[1:0]. A halfword access enables 4'hC when A[1] is 1, advancing by 2, and 4'hF otherwise, advancing by 4. Write data passes unshifted, and read data is the bus word masked to the enabled lanes.
- R8: Bank k accesses address {A[31:4], k[1:0], 2'b00} with the current size and never modifies the address register.
- R9: With `orun_en` high, a request accepted while a bus access is outstanding gets a response with `rsp_fault`=1 and no effect, and sets `sticky_orun`. While `sticky_orun` is set, every request is rejected the same way. A one-cycle `sticky_clr` pulse clears it.
- R10: With `orun_en` low, `req_ready` is 0 while a bus access is outstanding.
- R11: A bus error response sets `sticky_err`, cleared only by `sticky_clr`, and leaves the address register unchanged. A data read that ends in a bus error responds with `rsp_fault`=1.
- R12: `rsp_valid` and `rsp_rdata`, and `mem_req_valid` with its address and data, stay stable until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | REG_AW | Register byte offset |
| req_wdata | input | 32 | Register write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data |
| rsp_fault | output | 1 | Request rejected or bus error on read |
| orun_en | input | 1 | Overrun detection enable |
| sticky_clr | input | 1 | Clear both sticky flags |
| sticky_orun | output | 1 | Sticky overrun flag |
| sticky_err | output | 1 | Sticky bus error flag |
| mem_req_valid | output | 1 | Bus request valid |
| mem_req_ready | input | 1 | Bus request accepted |
| mem_req_write | output | 1 | Bus write |
| mem_req_addr | output | ADDR_W | Bus byte address |
| mem_req_be | output | 4 | Bus byte enables |
| mem_req_wdata | output | 32 | Bus write data |
| mem_rsp_valid | input | 1 | Bus response valid |
| mem_rsp_rdata | input | 32 | Bus read data |
| mem_rsp_err | input | 1 | Bus error on this response |

## Verification
A wrong address register is invisible until the next data access. It then shows at once on `mem_req_addr` and in the byte enables of that transaction, or on readback of offset 0x04. The bench therefore reads the register back after every step. Wrong lane logic appears on the same bus request as a bad enable or shifted data, and on reads one response later as a wrongly aligned or unmasked value. A stuck busy state shows as `req_ready` held low, or as a spurious overrun on the very next request.

// File: rtl/memap_pkg.sv
package memap_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xsize_e;

  typedef enum logic [1:0] {
    STEP_NONE   = 2'd0,
    STEP_SINGLE = 2'd1,
    STEP_PACKED = 2'd2,
    STEP_RSVD   = 2'd3
  } step_e;

  localparam logic [2:0] SLOT_CTRL = 3'd0;
  localparam logic [2:0] SLOT_ADDR = 3'd1;
  localparam logic [2:0] SLOT_DATA = 3'd3;

  localparam int unsigned LANES = 4;

  function automatic logic [31:0] lanes_to_mask(input logic [LANES-1:0] be);
    logic [31:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/memap_lane.sv
module memap_lane
  import memap_pkg::*;
(
  input  logic [1:0]  lo,
  input  xsize_e      size,
  input  logic        packed_en,
  input  logic [31:0] wdata,
  output logic [3:0]  be,
  output logic [31:0] bus_wdata,
  output logic [2:0]  adv,
  output logic [4:0]  shift,
  output logic [31:0] rmask
);

  always_comb begin
    be        = 4'hF;
    bus_wdata = wdata;
    adv       = 3'd4;
    shift     = 5'd0;
    rmask     = 32'hFFFF_FFFF;
    unique case (size)
      SZ_HALF: begin
        if (packed_en) begin
          be  = lo[1] ? 4'hC : 4'hF;
          adv = lo[1] ? 3'd2 : 3'd4;
          rmask = lanes_to_mask(be);
        end else begin
          be        = lo[1] ? 4'hC : 4'h3;
          shift     = lo[1] ? 5'd16 : 5'd0;
          bus_wdata = {16'h0, wdata[15:0]} << shift;
          adv       = 3'd2;
          rmask     = 32'h0000_FFFF;
        end
      end
      SZ_BYTE: begin
        if (packed_en) begin
          be    = 4'hF << lo;
          adv   = 3'd4 - {1'b0, lo};
          rmask = lanes_to_mask(be);
        end else begin
          be        = 4'h1 << lo;
          shift     = {lo, 3'b000};
          bus_wdata = {24'h0, wdata[7:0]} << shift;
          adv       = 3'd1;
          rmask     = 32'h0000_00FF;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/memap_tar_step.sv
module memap_tar_step #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 10
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        adv,
  output logic [ADDR_W-1:0] nxt
);

  localparam int PAD_W = WIN_BITS - 3;

  logic [WIN_BITS-1:0] low_sum;

  assign low_sum = cur[WIN_BITS-1:0] + {{PAD_W{1'b0}}, adv};
  assign nxt     = {cur[ADDR_W-1:WIN_BITS], low_sum};

endmodule

// File: rtl/memap_bus_seq.sv
module memap_bus_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [3:0]        start_be,
  input  logic [31:0]       start_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [3:0]        mem_req_be,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic [31:0]       done_rdata
);

  typedef enum logic [1:0] {BS_IDLE, BS_ISSUE, BS_WAIT} bstate_e;

  bstate_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= BS_IDLE;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_be    <= 4'h0;
      mem_req_wdata <= '0;
    end else begin
      unique case (state_q)
        BS_IDLE: if (start) begin
          state_q       <= BS_ISSUE;
          mem_req_write <= start_write;
          mem_req_addr  <= start_addr;
          mem_req_be    <= start_be;
          mem_req_wdata <= start_wdata;
        end
        BS_ISSUE: if (mem_req_ready) state_q <= BS_WAIT;
        BS_WAIT:  if (mem_rsp_valid) state_q <= BS_IDLE;
        default:  state_q <= BS_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == BS_ISSUE);
  assign busy          = (state_q != BS_IDLE);
  assign done          = (state_q == BS_WAIT) && mem_rsp_valid;
  assign done_err      = mem_rsp_err;
  assign done_rdata    = mem_rsp_rdata;

endmodule

// File: rtl/memap_engine.sv
module memap_engine
  import memap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 10,
  parameter int REG_AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_fault,
  input  logic              orun_en,
  input  logic              sticky_clr,
  output logic              sticky_orun,
  output logic              sticky_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [3:0]        mem_req_be,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err
);

  xsize_e            csw_size_q;
  step_e             csw_step_q;
  logic [ADDR_W-1:0] tar_q;
  logic              orun_q, err_q;
  logic              rsp_valid_q, rsp_fault_q;
  logic [31:0]       rsp_data_q;
  logic              rd_wait_q;
  logic              xfer_step_q;
  logic [2:0]        xfer_adv_q;
  logic [4:0]        xfer_sh_q;
  logic [31:0]       xfer_mask_q;

  logic [2:0]        slot;
  logic              mapped, is_data, banked;
  logic [ADDR_W-1:0] acc_addr;
  logic              busy, done, done_err;
  logic [31:0]       done_rdata;
  logic              accept, reject, go, start;
  logic              tar_wr;
  logic [3:0]        ln_be;
  logic [31:0]       ln_wdata, ln_mask;
  logic [2:0]        ln_adv;
  logic [4:0]        ln_sh;
  logic [ADDR_W-1:0] tar_nxt;
  logic [31:0]       reg_rdata;
  logic              unused_bits;

  assign unused_bits = ^{req_addr[1:0]};

  assign slot     = req_addr[4:2];
  assign mapped   = (req_addr[REG_AW-1:5] == '0);
  assign banked   = slot[2];
  assign is_data  = mapped && (banked || slot == SLOT_DATA);
  assign acc_addr = banked ? {tar_q[ADDR_W-1:4], slot[1:0], 2'b00} : tar_q;

  assign req_ready = !rsp_valid_q && !rd_wait_q && (!busy || orun_en);
  assign accept    = req_valid && req_ready;
  assign reject    = accept && (orun_q || busy);
  assign go        = accept && !reject;
  assign start     = go && is_data;
  assign tar_wr    = go && req_write && mapped && slot == SLOT_ADDR;

  memap_lane u_lane (
    .lo        (acc_addr[1:0]),
    .size      (csw_size_q),
    .packed_en (csw_step_q == STEP_PACKED && !banked),
    .wdata     (req_wdata),
    .be        (ln_be),
    .bus_wdata (ln_wdata),
    .adv       (ln_adv),
    .shift     (ln_sh),
    .rmask     (ln_mask)
  );

  memap_tar_step #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_step (
    .cur (tar_q),
    .adv (xfer_adv_q),
    .nxt (tar_nxt)
  );

  memap_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_write   (req_write),
    .start_addr    (acc_addr),
    .start_be      (ln_be),
    .start_wdata   (ln_wdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_be    (mem_req_be),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .mem_rsp_err   (mem_rsp_err),
    .busy          (busy),
    .done          (done),
    .done_err      (done_err),
    .done_rdata    (done_rdata)
  );

  always_comb begin
    reg_rdata = 32'h0;
    if (mapped) begin
      unique case (slot)
        SLOT_CTRL: reg_rdata = {24'h0, busy, 1'b0, csw_step_q, 2'b00, csw_size_q};
        SLOT_ADDR: reg_rdata = 32'(tar_q);
        default:   reg_rdata = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csw_size_q  <= SZ_BYTE;
      csw_step_q  <= STEP_NONE;
      tar_q       <= '0;
      orun_q      <= 1'b0;
      err_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_data_q  <= '0;
      rd_wait_q   <= 1'b0;
      xfer_step_q <= 1'b0;
      xfer_adv_q  <= '0;
      xfer_sh_q   <= '0;
      xfer_mask_q <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;

      if (sticky_clr) begin
        orun_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (accept && busy) orun_q <= 1'b1;

      if (reject) begin
        rsp_valid_q <= 1'b1;
        rsp_fault_q <= 1'b1;
        rsp_data_q  <= 32'h0;
      end else if (go) begin
        if (is_data && !req_write) begin
          rd_wait_q <= 1'b1;
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_fault_q <= 1'b0;
          rsp_data_q  <= req_write ? 32'h0 : reg_rdata;
        end
        if (req_write && mapped && slot == SLOT_CTRL) begin
          csw_size_q <= xsize_e'(req_wdata[1:0]);
          csw_step_q <= step_e'(req_wdata[5:4]);
        end
        if (tar_wr) tar_q <= req_wdata[ADDR_W-1:0];
        if (start) begin
          xfer_step_q <= !banked && (csw_step_q == STEP_SINGLE || csw_step_q == STEP_PACKED);
          xfer_adv_q  <= ln_adv;
          xfer_sh_q   <= ln_sh;
          xfer_mask_q <= ln_mask;
        end
      end

      if (done) begin
        if (rd_wait_q) begin
          rd_wait_q   <= 1'b0;
          rsp_valid_q <= 1'b1;
          rsp_fault_q <= done_err;
          rsp_data_q  <= (done_rdata >> xfer_sh_q) & xfer_mask_q;
        end
        if (done_err) err_q <= 1'b1;
        else if (xfer_step_q) tar_q <= tar_nxt;
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_data_q;
  assign rsp_fault   = rsp_fault_q;
  assign sticky_orun = orun_q;
  assign sticky_err  = err_q;

endmodule

// File: rtl/memap_engine_chk.sv
module memap_engine_chk #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              orun_en,
  input logic              sticky_clr,
  input logic              sticky_orun,
  input logic              sticky_err,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [3:0]        mem_req_be,
  input logic [31:0]       mem_req_wdata,
  input logic [ADDR_W-1:0] tar_q,
  input logic              tar_wr
);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata));

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R9
  orun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_orun && !sticky_clr |=> sticky_orun);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_err && !sticky_clr |=> sticky_err);

  // R10
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !orun_en && mem_req_valid |-> !req_ready);

  // R3
  lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_be != 4'h0);

  // R6
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tar_q != $past(tar_q)) && !$past(tar_wr)
      |-> tar_q[ADDR_W-1:WIN_BITS] == $past(tar_q[ADDR_W-1:WIN_BITS]));

endmodule

bind memap_engine memap_engine_chk #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) chk_i (.*);

// File: tb/memap_engine_tb_top.sv
`timescale 1ns/1ps
module memap_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        orun_en = 1'b0, sticky_clr = 1'b0;
  logic        sticky_orun, sticky_err;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  int n_chk = 0, n_fail = 0, lat = 1;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_be;
  logic [31:0] rd;
  logic        flt;

  always #10 clk = ~clk;

  memap_engine dut_i (.*);

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  function automatic logic [3:0] e_be(input int sz, input bit pk, input logic [1:0] lo);
    if (sz == 2) return 4'hF;
    if (sz == 1) return lo[1] ? 4'hC : (pk ? 4'hF : 4'h3);
    return pk ? 4'(4'hF << lo) : 4'(4'h1 << lo);
  endfunction

  function automatic int e_adv(input int sz, input bit pk, input logic [1:0] lo);
    if (sz == 2) return 4;
    if (sz == 1) return pk ? (lo[1] ? 2 : 4) : 2;
    return pk ? 4 - int'(lo) : 1;
  endfunction

  function automatic logic [31:0] e_wd(input int sz, input bit pk, input logic [1:0] lo, input logic [31:0] d);
    if (sz == 2 || pk) return d;
    if (sz == 1) return (d & 32'hFFFF) << (16 * lo[1]);
    return (d & 32'hFF) << (8 * lo);
  endfunction

  function automatic logic [31:0] e_rd(input int sz, input bit pk, input logic [31:0] a);
    logic [31:0] p, m;
    logic [3:0] b;
    p = pat(a);
    if (sz == 2) return p;
    if (pk) begin
      b = e_be(sz, 1'b1, a[1:0]);
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{b[i]}};
      return p & m;
    end
    if (sz == 1) return (p >> (16 * a[1])) & 32'hFFFF;
    return (p >> (8 * a[1:0])) & 32'hFF;
  endfunction

  function automatic logic [31:0] e_step(input logic [31:0] t, input int adv);
    logic [9:0] lo10;
    lo10 = t[9:0] + 10'(adv);
    return {t[31:10], lo10};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        cap_addr  = mem_req_addr;
        cap_wdata = mem_req_wdata;
        cap_be    = mem_req_be;
        repeat (lat) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = pat(cap_addr);
        mem_rsp_err   = (cap_addr[31:28] == 4'hE);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
      end
    end
  end

  task automatic ap(input bit w, input logic [7:0] a, input logic [31:0] d,
                    output logic [31:0] r, output logic f);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r = rsp_rdata; f = rsp_fault;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (lat + 8) @(negedge clk);
  endtask

  task automatic clr_sticky();
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] base, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 mem_req_valid", mem_req_valid, 0);
    check("R1 stickies", {sticky_orun, sticky_err}, 0);
    ap(0, 8'h00, 0, rd, flt); check("R1 ctrl", rd, 0);
    ap(0, 8'h04, 0, rd, flt); check("R1 addr", rd, 0);

    // R2 readback and unmapped offsets
    ap(1, 8'h00, 32'h0000_0012, rd, flt);
    ap(0, 8'h00, 0, rd, flt); check("R2 ctrl readback", rd, 32'h12);
    ap(1, 8'h04, 32'hCAFE_0100, rd, flt);
    ap(1, 8'h08, 32'hFFFF_FFFF, rd, flt);
    ap(1, 8'h40, 32'hFFFF_FFFF, rd, flt);
    ap(0, 8'h08, 0, rd, flt); check("R2 unmapped 0x08", rd, 0);
    ap(0, 8'h40, 0, rd, flt); check("R2 unmapped 0x40", rd, 0);
    ap(0, 8'h04, 0, rd, flt); check("R2 addr untouched", rd, 32'hCAFE_0100);
    ap(0, 8'h00, 0, rd, flt); check("R2 ctrl untouched", rd, 32'h12);

    // R3 R4 R5 single-mode sweep
    for (int sz = 0; sz < 3; sz++) begin
      for (int lo = 0; lo < 4; lo++) begin
        base = 32'h4000_0100 + lo;
        ap(1, 8'h00, 32'h10 | sz, rd, flt);
        ap(1, 8'h04, base, rd, flt);
        ap(1, 8'h0C, 32'hA1B2_C3D4, rd, flt);
        settle();
        check("R3 addr", cap_addr, base);
        check("R3 be", cap_be, e_be(sz, 0, 2'(lo)));
        check("R3 wdata", cap_wdata, e_wd(sz, 0, 2'(lo), 32'hA1B2_C3D4));
        t = base + e_adv(sz, 0, 2'(lo));
        ap(0, 8'h04, 0, rd, flt); check("R5 single step", rd, t);
        ap(0, 8'h0C, 0, rd, flt); check("R4 read lane", rd, e_rd(sz, 0, t));
        ap(0, 8'h04, 0, rd, flt); check("R5 step after read", rd, t + e_adv(sz, 0, t[1:0]));
      end
    end

    // R5 mode none
    ap(1, 8'h00, 32'h02, rd, flt);
    ap(1, 8'h04, 32'h4000_0200, rd, flt);
    ap(1, 8'h0C, 32'h1, rd, flt); settle();
    ap(0, 8'h04, 0, rd, flt); check("R5 none no step", rd, 32'h4000_0200);

    // R7 packed sweep
    for (int sz = 0; sz < 2; sz++) begin
      for (int lo = 0; lo < 4; lo++) begin
        base = 32'h5000_0040 + lo;
        ap(1, 8'h00, 32'h20 | sz, rd, flt);
        ap(1, 8'h04, base, rd, flt);
        ap(1, 8'h0C, 32'h8765_4321, rd, flt);
        settle();
        check("R7 be", cap_be, e_be(sz, 1, 2'(lo)));
        check("R7 wdata", cap_wdata, 32'h8765_4321);
        t = base + e_adv(sz, 1, 2'(lo));
        ap(0, 8'h04, 0, rd, flt); check("R7 step", rd, t);
        ap(0, 8'h0C, 0, rd, flt); check("R7 read mask", rd, e_rd(sz, 1, t));
      end
    end

    // R6 window wrap
    ap(1, 8'h00, 32'h12, rd, flt);
    ap(1, 8'h04, 32'h1234_57FC, rd, flt);
    ap(1, 8'h0C, 0, rd, flt); settle();
    ap(0, 8'h04, 0, rd, flt); check("R6 word wrap", rd, e_step(32'h1234_57FC, 4));
    ap(1, 8'h00, 32'h10, rd, flt);
    ap(1, 8'h04, 32'h0000_03FF, rd, flt);
    ap(1, 8'h0C, 0, rd, flt); settle();
    ap(0, 8'h04, 0, rd, flt); check("R6 byte wrap", rd, 32'h0000_0000);
    ap(1, 8'h00, 32'h20, rd, flt);
    ap(1, 8'h04, 32'h7777_FFFE, rd, flt);
    ap(1, 8'h0C, 0, rd, flt); settle();
    ap(0, 8'h04, 0, rd, flt); check("R6 packed wrap", rd, 32'h7777_FC00);

    // R8 banked
    ap(1, 8'h00, 32'h12, rd, flt);
    ap(1, 8'h04, 32'h2000_123C, rd, flt);
    ap(1, 8'h18, 32'h5555_AAAA, rd, flt); settle();
    check("R8 bank2 addr", cap_addr, 32'h2000_1238);
    check("R8 bank2 data", cap_wdata, 32'h5555_AAAA);
    ap(0, 8'h14, 0, rd, flt); check("R8 bank1 read", rd, pat(32'h2000_1234));
    ap(0, 8'h04, 0, rd, flt); check("R8 addr kept", rd, 32'h2000_123C);

    // R11 bus error
    ap(1, 8'h04, 32'hE000_0010, rd, flt);
    ap(1, 8'h0C, 0, rd, flt); settle();
    check("R11 sticky_err", sticky_err, 1);
    ap(0, 8'h04, 0, rd, flt); check("R11 no step", rd, 32'hE000_0010);
    ap(0, 8'h0C, 0, rd, flt); check("R11 read fault", flt, 1);
    clr_sticky();
    check("R11 cleared", sticky_err, 0);

    // R10 back-pressure
    lat = 8; orun_en = 1'b0;
    ap(1, 8'h04, 32'h3000_0000, rd, flt);
    ap(1, 8'h0C, 1, rd, flt);
    check("R10 ready low while busy", req_ready, 0);
    settle();
    check("R10 ready after", req_ready, 1);
    check("R10 no overrun", sticky_orun, 0);

    // R9 overrun
    orun_en = 1'b1;
    ap(1, 8'h0C, 2, rd, flt);
    ap(0, 8'h00, 0, rd, flt);
    check("R9 reject fault", flt, 1);
    check("R9 sticky set", sticky_orun, 1);
    settle();
    ap(0, 8'h04, 0, rd, flt); check("R9 still rejected", flt, 1);
    clr_sticky();
    ap(0, 8'h04, 0, rd, flt);
    check("R9 accepted after clear", flt, 0);
    check("R9 addr after clear", rd, 32'h3000_0008);
    orun_en = 1'b0; lat = 1;

    // R12 response hold
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h04;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 rsp held", rsp_valid, 1);
    check("R12 rsp data", rsp_rdata, 32'h3000_0008);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 rsp consumed", rsp_valid, 0);

    finish_run();
  end

endmodule